// File: doc/BRIEF.md
# Indexed Saturating Doubling Multiply-Accumulate Lanes

This block is a SIMD datapath for wide vectors. It splits a vector of `VLEN` bits into independent 128-bit segments and computes every segment in parallel. Within each segment, each double-width accumulator lane takes the even-numbered narrow signed element of operand A that sits at the bottom of that lane. It multiplies this element by a single narrow signed element of operand B, which a 3-bit index picks and which is shared by every lane of the segment. The product is doubled and clamped to the signed double-width range. It is then added to the lane's accumulator value, and the sum is clamped again.

A size input chooses the lane shape for each operation: 16-bit narrow elements giving 32-bit results, or 32-bit narrow elements giving 64-bit results. Results, per-slot saturation flags and a valid strobe are registered, so each appears one clock after the operands. Instruction decoding, register storage and predication belong to the surrounding pipeline.

Top module: `sat_dmla_idx`

## Requirements
- R1: With `wide`=0, 32-bit result lane e (bits 32e+31..32e) equals clamp32(acc lane e + clamp32(2 × A16[2e] × B16[8s+idx])). Here narrow element k occupies bits 16k+15..16k and s = e/4 is the segment number.
- R2: With `wide`=1, 64-bit result lane e (bits 64e+63..64e) equals clamp64(acc lane e + clamp64(2 × A32[2e] × B32[4s+idx[1:0]])). Here narrow element k occupies bits 32k+31..32k and s = e/2.
- R3: When both multiplicands are the most negative narrow value, the doubled product clamps to the largest positive double-width value before it is added.
- R4: A sum above the double-width maximum returns the maximum, and a sum below the minimum returns the minimum.
- R5: Each 128-bit segment takes its B multiplier from within its own segment, at the same index position in every segment.
- R6: With `wide`=1, `idx[2]` is ignored.
- R7: Odd-numbered narrow elements of A, and all B elements that the index does not select, have no effect on the result.
- R8: `valid_out` equals `valid_in` delayed by one clock. A synchronous `rst` clears `valid_out`, `result` and `sat_flag` to zero.
- R9: `result` and `sat_flag` load only in cycles when `valid_in` is high and hold their values otherwise.
- R10: `sat_flag` has one bit per 32-bit slot. A bit is 1 when the product clamp or the sum clamp engaged for the result covering that slot. With `wide`=1, both slots of a 64-bit result carry that result's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands valid this cycle |
| wide | input | 1 | 0: 16→32-bit lanes, 1: 32→64-bit lanes |
| idx | input | 3 | Element index of B within each segment |
| opa | input | VLEN | First multiplicand vector |
| opb | input | VLEN | Indexed multiplicand vector |
| acc | input | VLEN | Accumulator input vector |
| valid_out | output | 1 | Result valid |
| result | output | VLEN | Saturated accumulator results |
| sat_flag | output | VLEN/32 | Per 32-bit slot saturation indicator |

## Verification
The bench targets the product of two most-negative values. A design that doubles this product without clamping wraps it to the most negative number, and the error then spreads through the accumulation. It drives sums that cross the upper bound and the lower bound. A wrapping adder shows up there as a sign flip. It fills the odd A elements and the unselected B elements with distinct junk, so a wrong element pick or a lane that does not reset its segment base yields garbage. It also sets idx[2] in wide mode, where an index that is not masked reads past the segment.

// File: rtl/sat_dmla_idx.sv
module sat_dmla_idx #(
  parameter int VLEN = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  logic                 wide,
  input  logic [2:0]           idx,
  input  logic [VLEN-1:0]      opa,
  input  logic [VLEN-1:0]      opb,
  input  logic [VLEN-1:0]      acc,
  output logic                 valid_out,
  output logic [VLEN-1:0]      result,
  output logic [VLEN/32-1:0]   sat_flag
);

  localparam int SEGS = VLEN / 128;
  localparam int SLOTS = VLEN / 32;

  logic [1:0][VLEN-1:0]  res_v;
  logic [1:0][SLOTS-1:0] sat_v;

  wire unused_bits = ^opa;

  for (genvar g = 0; g < 2; g++) begin : g_var
    localparam int NW  = 16 << g;
    localparam int DW  = 2 * NW;
    localparam int PER = 128 / DW;
    localparam int FW  = DW / 32;
    localparam logic [NW-1:0] NMIN = {1'b1, {(NW-1){1'b0}}};
    localparam logic [DW-1:0] DMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};

    wire [2:0] sel = (g == 1) ? {1'b0, idx[1:0]} : idx;

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
      wire [127:0]   bseg = opb[s*128 +: 128];
      wire [NW-1:0]  bm   = bseg[sel*NW +: NW];

      for (genvar j = 0; j < PER; j++) begin : g_lane
        localparam int E = s * PER + j;
        wire [NW-1:0] am = opa[E*DW +: NW];
        wire [DW-1:0] ac = acc[E*DW +: DW];
        wire signed [DW-1:0] pr = $signed({{NW{am[NW-1]}}, am}) *
                                  $signed({{NW{bm[NW-1]}}, bm});
        wire          pov = (am == NMIN) && (bm == NMIN);
        wire [DW-1:0] pd  = pov ? DMAX : {pr[DW-2:0], 1'b0};
        wire [DW:0]   sm  = {ac[DW-1], ac} + {pd[DW-1], pd};
        wire          sov = sm[DW] ^ sm[DW-1];

        assign res_v[g][E*DW +: DW] = sov ? (sm[DW] ? DMIN : DMAX) : sm[DW-1:0];
        assign sat_v[g][E*FW +: FW] = {FW{pov | sov}};
      end
    end
  end

  logic wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      result    <= '0;
      sat_flag  <= '0;
      wide_q    <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result   <= res_v[wide];
        sat_flag <= sat_v[wide];
        wide_q   <= wide;
      end
    end
  end

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!valid_out && result == '0 && sat_flag == '0));

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  assert_valid_drop_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> ($stable(result) && $stable(sat_flag)));

  for (genvar m = 0; m < SLOTS / 2; m++) begin : g_pair_chk
    assert_flag_pair_R10: assert property (@(posedge clk) disable iff (rst)
      (valid_out && wide_q) |-> (sat_flag[2*m] == sat_flag[2*m+1]));
  end

endmodule

// File: tb/test_sat_dmla_idx.sv
module test_sat_dmla_idx;
  localparam int VLEN  = 256;
  localparam int SLOTS = VLEN / 32;

  typedef struct packed {
    logic        wide;
    logic [2:0]  ix;
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] c;
    logic [63:0] exp;
    logic        sat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TAB [NV] = '{
    '{1'b0, 3'd0, 32'h0003, 32'h0005, 64'h0000000A, 64'h00000028, 1'b0},
    '{1'b0, 3'd3, 32'hFFFE, 32'h0007, 64'h00000064, 64'h00000048, 1'b0},
    '{1'b0, 3'd7, 32'h8000, 32'h8000, 64'h00000000, 64'h7FFFFFFF, 1'b1},
    '{1'b0, 3'd2, 32'h8000, 32'h8000, 64'hFFFFFFFF, 64'h7FFFFFFE, 1'b1},
    '{1'b0, 3'd5, 32'h7FFF, 32'h7FFF, 64'h7FFFFFFF, 64'h7FFFFFFF, 1'b1},
    '{1'b0, 3'd1, 32'h8000, 32'h7FFF, 64'h80000000, 64'h80000000, 1'b1},
    '{1'b0, 3'd4, 32'h8000, 32'h7FFF, 64'h7FFFFFFF, 64'h0000FFFF, 1'b0},
    '{1'b1, 3'd2, 32'h80000000, 32'h80000000, 64'h0, 64'h7FFFFFFFFFFFFFFF, 1'b1},
    '{1'b1, 3'd3, 32'h000003E8, 32'hFFFFFFFD, 64'h0, 64'hFFFFFFFFFFFFE890, 1'b0},
    '{1'b1, 3'd6, 32'h7FFFFFFF, 32'h7FFFFFFF, 64'h7FFFFFFFFFFFFFFF, 64'h7FFFFFFFFFFFFFFF, 1'b1},
    '{1'b1, 3'd0, 32'h80000000, 32'h7FFFFFFF, 64'h8000000000000000, 64'h8000000000000000, 1'b1},
    '{1'b1, 3'd1, 32'h00000002, 32'h00000003, 64'hFFFFFFFFFFFFFFF0, 64'hFFFFFFFFFFFFFFFC, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, valid_in = 1'b0, wide = 1'b0;
  logic [2:0] idx = '0;
  logic [VLEN-1:0] opa = '0, opb = '0, acc = '0;
  logic valid_out;
  logic [VLEN-1:0] result;
  logic [SLOTS-1:0] sat_flag;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sat_dmla_idx #(.VLEN(VLEN)) i_sat_dmla_idx (
    .clk(clk), .rst(rst), .valid_in(valid_in), .wide(wide), .idx(idx),
    .opa(opa), .opb(opb), .acc(acc),
    .valid_out(valid_out), .result(result), .sat_flag(sat_flag));

  task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill(input vec_t v);
    wide = v.wide; idx = v.ix;
    if (!v.wide) begin
      for (int k = 0; k < VLEN/16; k++) begin
        opa[16*k +: 16] = (k % 2 == 0) ? v.a[15:0] : (16'h4321 ^ 16'(k));
        opb[16*k +: 16] = (k % 8 == int'(v.ix)) ? v.b[15:0] : (16'h1234 + 16'(k));
      end
      for (int e = 0; e < VLEN/32; e++) acc[32*e +: 32] = v.c[31:0];
    end else begin
      for (int k = 0; k < VLEN/32; k++) begin
        opa[32*k +: 32] = (k % 2 == 0) ? v.a : (32'h0BAD0000 + 32'(k));
        opb[32*k +: 32] = (k % 4 == int'(v.ix[1:0])) ? v.b : (32'h00770000 + 32'(k));
      end
      for (int e = 0; e < VLEN/64; e++) acc[64*e +: 64] = v.c;
    end
  endtask

  function automatic logic signed [127:0] sx(input logic [VLEN-1:0] v, input int pos, input int w);
    logic signed [127:0] one = 128'sd1;
    logic signed [127:0] raw = $signed({1'b0, (v >> pos)}) & ((one <<< w) - 1);
    if (raw[w-1]) raw = raw - (one <<< w);
    return raw;
  endfunction

  task automatic model(input bit wd, input logic [2:0] ix, input logic [VLEN-1:0] a, b, c,
                       output logic [VLEN-1:0] r, output logic [SLOTS-1:0] f);
    logic signed [127:0] one = 128'sd1;
    int nw = wd ? 32 : 16;
    int dw = 2 * nw;
    int per = 128 / dw;
    int sel = wd ? int'(ix[1:0]) : int'(ix);
    logic signed [127:0] hi = (one <<< (dw - 1)) - 1;
    logic signed [127:0] lo = -(one <<< (dw - 1));
    r = '0; f = '0;
    for (int e = 0; e < VLEN / dw; e++) begin
      int s = e / per;
      logic signed [127:0] ea = sx(a, 2 * e * nw, nw);
      logic signed [127:0] eb = sx(b, (s * (128 / nw) + sel) * nw, nw);
      logic signed [127:0] ec = sx(c, e * dw, dw);
      logic signed [127:0] p = 2 * ea * eb;
      logic signed [127:0] t;
      bit st = 1'b0;
      if (p > hi) begin p = hi; st = 1'b1; end
      t = ec + p;
      if (t > hi) begin t = hi; st = 1'b1; end
      if (t < lo) begin t = lo; st = 1'b1; end
      for (int q = 0; q < dw; q++) r[e*dw + q] = t[q];
      for (int q = 0; q < dw / 32; q++) f[e*(dw/32) + q] = st;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] er, held, r1;
    logic [SLOTS-1:0] ef, hf;
    repeat (3) @(negedge clk);
    chk("R8 reset valid_out", VLEN'(valid_out), '0);
    chk("R8 reset result", result, '0);
    chk("R8 reset sat_flag", VLEN'(sat_flag), '0);
    rst = 1'b0;

    // table walk: R1..R4, R6, R7, R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fill(TAB[i]); valid_in = 1'b1;
      @(negedge clk);
      chk("R8 valid_out high", VLEN'(valid_out), VLEN'(1));
      if (!TAB[i].wide)
        for (int e = 0; e < VLEN/32; e++)
          chk($sformatf("R1/R3/R4/R7 vec %0d lane %0d", i, e), VLEN'(result[32*e +: 32]), VLEN'(TAB[i].exp[31:0]));
      else
        for (int e = 0; e < VLEN/64; e++)
          chk($sformatf("R2/R3/R4/R6/R7 vec %0d lane %0d", i, e), VLEN'(result[64*e +: 64]), VLEN'(TAB[i].exp));
      chk($sformatf("R10 flags vec %0d", i), VLEN'(sat_flag), VLEN'({SLOTS{TAB[i].sat}}));
    end

    // R5: distinct data per segment against the model
    for (int it = 0; it < 40; it++) begin
      @(negedge clk);
      wide = it[0]; idx = 3'($urandom);
      for (int k = 0; k < VLEN/32; k++) begin
        opa[32*k +: 32] = (it % 5 == 0) ? 32'h80008000 : $urandom;
        opb[32*k +: 32] = (it % 5 == 0) ? 32'h80008000 : $urandom;
        acc[32*k +: 32] = $urandom;
      end
      valid_in = 1'b1;
      model(wide, idx, opa, opb, acc, er, ef);
      @(negedge clk);
      chk($sformatf("R5 model result it %0d", it), result, er);
      chk($sformatf("R10 model flags it %0d", it), VLEN'(sat_flag), VLEN'(ef));
    end

    // R6: idx 1 vs idx 5 in wide mode yield identical results
    @(negedge clk);
    wide = 1'b1; idx = 3'd1;
    for (int k = 0; k < VLEN/32; k++) begin
      opa[32*k +: 32] = 32'h00010000 + 32'(k*7);
      opb[32*k +: 32] = 32'h00020000 + 32'(k*13);
      acc[32*k +: 32] = 32'(k);
    end
    @(negedge clk);
    r1 = result;
    idx = 3'd5;
    @(negedge clk);
    chk("R6 idx[2] ignored in wide mode", result, r1);

    // R9: idle cycle holds outputs despite new operands
    held = result; hf = sat_flag;
    valid_in = 1'b0; opa = ~opa; acc = ~acc; wide = 1'b0;
    @(negedge clk);
    chk("R8 valid_out low", VLEN'(valid_out), '0);
    chk("R9 result held", result, held);
    chk("R9 flags held", VLEN'(sat_flag), VLEN'(hf));

    // R8: reset during a valid cycle clears everything
    fill(TAB[2]); valid_in = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R8 mid reset valid_out", VLEN'(valid_out), '0);
    chk("R8 mid reset result", result, '0);
    chk("R8 mid reset flags", VLEN'(sat_flag), '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule